// File: doc/BRIEF.md
# CAN Mode Control Register

This block holds the 32-bit mode word that a CAN controller's host writes to pick its operating modes. It sits at a single address on a simple register bus. Writes land in one clock cycle, and reads come back combinationally. Some fields can be written at any time. Others open only while the controller is held in initialization with configuration changes unlocked. One field can always be cleared but can be set only under that same condition. Each field drives a mode line into the CAN core.

The initialization flag crosses into the protocol clock domain and is acknowledged back. Its read-back value is the acknowledged copy, so a write becomes visible only after that round trip. A clock-stop request forces initialization on. The acknowledge rises only once the core reports no pending transmissions and an idle bus.

Top module: `can_mode_ctrl`

## Requirements
- R1: After reset the word reads 0x00000001: init (bit 0) is 1 and every other bit is 0. All mode outputs are 0 and `protoInit` is 1.
- R2: The unrestricted fields accept any write, whatever the init and config-unlock state, and show on read and on their outputs one cycle later. These fields are FD enable (bit 8), bit-rate switch (bit 9), exception-handling disable (bit 12), edge filter (bit 13) and transmit pause (bit 14).
- R3: Config unlock (bit 1) takes a written value only while init reads 1. Otherwise it keeps its value.
- R4: Test (bit 7), monitor (bit 5) and restricted mode (bit 2) always accept a 0. A 1 takes effect only when init and config unlock both read 1 at the time of the write; otherwise the bit keeps its value.
- R5: Retransmission disable (bit 6) changes, in either direction, only when init and config unlock both read 1 at the time of the write.
- R6: Bit 0 reads the init value acknowledged by the protocol domain. A new value reaches `protoInit` and the read-back between 2 and 16 cycles after the write.
- R7: A write that would change init is ignored while an earlier change is still crossing domains.
- R8: An accepted write that clears init clears config unlock in the same cycle. Config unlock never reads 1 while init reads 0.
- R9: Setting clock-stop request (bit 4) forces init to 1. Clock-stop acknowledge (bit 3) rises one cycle after an edge where init reads 1, `txPending` is 0 and `busIdle` is 1, and not before.
- R10: Clearing the clock-stop request clears the acknowledge on the same edge. Writes to bit 3 itself are ignored.
- R11: Bits 10, 11 and 15–31 read 0 and ignore writes. A write to any other address changes nothing, and a read of another address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register bus clock |
| rstN | input | 1 | Asynchronous active-low reset, bus domain |
| protoClk | input | 1 | Protocol domain clock |
| protoRstN | input | 1 | Asynchronous active-low reset, protocol domain |
| busWrEn | input | 1 | Write strobe |
| busAddr | input | ADDR_W | Register address |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data (0 when the address does not match) |
| txPending | input | 1 | Core still has transmit requests outstanding |
| busIdle | input | 1 | Core sees the CAN bus idle |
| protoInit | output | 1 | Init flag in the protocol clock domain |
| fdEnable | output | 1 | Flexible data-rate frames enabled |
| brsEnable | output | 1 | Bit-rate switching on transmit enabled |
| txPause | output | 1 | Pause between own transmissions |
| edgeFilter | output | 1 | Edge filtering during bus integration |
| excDisable | output | 1 | Protocol exception handling disabled |
| testMode | output | 1 | Test mode |
| monitorMode | output | 1 | Listen-only bus monitoring |
| restrictedMode | output | 1 | Restricted operation |
| noRetransmit | output | 1 | Automatic retransmission disabled |
| clockStopAck | output | 1 | Clocks may now be stopped |

## Verification
Every field except init is a single register stage behind the write edge. The bench drives a write on a falling edge, lets one rising edge pass, and samples at the next falling edge. The clock-stop acknowledge follows the same one-edge rule after its inputs change, so the bench moves `txPending` and `busIdle` on falling edges and samples one cycle later. The init read-back depends on two unrelated clocks, so the bench polls it for at most 16 cycles and checks that the count lies inside the bound. After that it holds for several more cycles to confirm that a write ignored while the change was in flight never lands.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;
  localparam int REG_W = 32;

  localparam int BIT_INIT     = 0;
  localparam int BIT_CFGEN    = 1;
  localparam int BIT_RESTR    = 2;
  localparam int BIT_STOPACK  = 3;
  localparam int BIT_STOPREQ  = 4;
  localparam int BIT_MON      = 5;
  localparam int BIT_NORETX   = 6;
  localparam int BIT_TEST     = 7;
  localparam int BIT_FD       = 8;
  localparam int BIT_BRS      = 9;
  localparam int BIT_NOEXC    = 12;
  localparam int BIT_EDGEFLT  = 13;
  localparam int BIT_TXPAUSE  = 14;

  localparam int PLAIN_N = 5;
  localparam int GUARD_N = 3;

  typedef struct packed {
    logic wrHit;
    logic initLd;
    logic initVal;
    logic cfgEnLd;
    logic cfgEnVal;
    logic guardOpen;
    logic noRetxLd;
    logic stopReqVal;
    logic stopAckSet;
    logic stopAckClr;
  } wrStrobe_t;
endpackage

// File: rtl/can_mode_wr_ctrl.sv
module can_mode_wr_ctrl
  import can_mode_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 'h18
) (
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWrData,
  input  logic              initReq,
  input  logic              initRead,
  input  logic              initBusy,
  input  logic              cfgEn,
  input  logic              stopReq,
  input  logic              txPending,
  input  logic              busIdle,
  output wrStrobe_t         strobe
);
  logic wrHit;
  logic stopReqNext;
  logic initWant;
  logic initSettledHigh;
  logic initClearing;
  logic unusedData;

  assign unusedData = ^{busWrData[REG_W-1:BIT_STOPREQ+1], busWrData[BIT_STOPACK:BIT_RESTR]};

  always_comb begin
    wrHit           = busWrEn && (busAddr == REG_OFFSET);
    stopReqNext     = wrHit ? busWrData[BIT_STOPREQ] : stopReq;
    // a pending clock stop pins init high
    initWant        = stopReqNext ? 1'b1 : (wrHit ? busWrData[BIT_INIT] : initReq);
    initSettledHigh = initRead && initReq;
    initClearing    = !initBusy && (initWant != initReq) && !initWant;

    strobe            = '0;
    strobe.wrHit      = wrHit;
    strobe.initLd     = !initBusy && (initWant != initReq);
    strobe.initVal    = initWant;
    strobe.cfgEnLd    = initClearing || (wrHit && initSettledHigh);
    strobe.cfgEnVal   = initClearing ? 1'b0 : busWrData[BIT_CFGEN];
    strobe.guardOpen  = initSettledHigh && cfgEn;
    strobe.noRetxLd   = wrHit && initSettledHigh && cfgEn;
    strobe.stopReqVal = stopReqNext;
    strobe.stopAckSet = stopReqNext && initSettledHigh && !txPending && busIdle;
    strobe.stopAckClr = !stopReqNext;
  end
endmodule

// File: rtl/can_mode_regs.sv
module can_mode_regs
  import can_mode_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  wrStrobe_t        strobe,
  input  logic [REG_W-1:0] busWrData,
  input  logic             initRead,
  output logic             initReq,
  output logic             cfgEn,
  output logic             stopReq,
  output logic [REG_W-1:0] regVal
);
  localparam int PLAIN_POS [PLAIN_N] = '{BIT_FD, BIT_BRS, BIT_NOEXC, BIT_EDGEFLT, BIT_TXPAUSE};
  localparam int GUARD_POS [GUARD_N] = '{BIT_TEST, BIT_MON, BIT_RESTR};

  logic [PLAIN_N-1:0] plainQ;
  logic [GUARD_N-1:0] guardQ;
  logic               noRetxQ;
  logic               stopAckQ;
  logic               unusedData;

  assign unusedData = ^{busWrData[REG_W-1:BIT_TXPAUSE+1], busWrData[BIT_NOEXC-1:BIT_BRS+1],
                        busWrData[BIT_STOPACK]};

  for (genvar i = 0; i < PLAIN_N; i++) begin : g_plain
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             plainQ[i] <= 1'b0;
      else if (strobe.wrHit) plainQ[i] <= busWrData[PLAIN_POS[i]];
    end
  end

  for (genvar i = 0; i < GUARD_N; i++) begin : g_guard
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             guardQ[i] <= 1'b0;
      else if (strobe.wrHit) guardQ[i] <= busWrData[GUARD_POS[i]] & (guardQ[i] | strobe.guardOpen);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initReq  <= 1'b1;
      cfgEn    <= 1'b0;
      noRetxQ  <= 1'b0;
      stopReq  <= 1'b0;
      stopAckQ <= 1'b0;
    end else begin
      if (strobe.initLd)   initReq <= strobe.initVal;
      if (strobe.cfgEnLd)  cfgEn   <= strobe.cfgEnVal;
      if (strobe.noRetxLd) noRetxQ <= busWrData[BIT_NORETX];
      stopReq <= strobe.stopReqVal;
      if (strobe.stopAckClr)      stopAckQ <= 1'b0;
      else if (strobe.stopAckSet) stopAckQ <= 1'b1;
    end
  end

  always_comb begin
    regVal = '0;
    regVal[BIT_INIT]    = initRead;
    regVal[BIT_CFGEN]   = cfgEn;
    regVal[BIT_NORETX]  = noRetxQ;
    regVal[BIT_STOPREQ] = stopReq;
    regVal[BIT_STOPACK] = stopAckQ;
    for (int i = 0; i < PLAIN_N; i++) regVal[PLAIN_POS[i]] = plainQ[i];
    for (int i = 0; i < GUARD_N; i++) regVal[GUARD_POS[i]] = guardQ[i];
  end
endmodule

// File: rtl/can_init_xfer.sv
module can_init_xfer #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic protoClk,
  input  logic protoRstN,
  input  logic initReq,
  output logic protoInit,
  output logic initRead,
  output logic initBusy
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] fwdSync;
  logic [MSB:0] backSync;

  always_ff @(posedge protoClk or negedge protoRstN) begin
    if (!protoRstN) fwdSync <= '1;
    else            fwdSync <= {fwdSync[MSB-1:0], initReq};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) backSync <= '1;
    else       backSync <= {backSync[MSB-1:0], protoInit};
  end

  assign protoInit = fwdSync[MSB];
  assign initRead  = backSync[MSB];
  assign initBusy  = initReq != initRead;
endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
  import can_mode_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 'h18,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              protoClk,
  input  logic              protoRstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  input  logic              txPending,
  input  logic              busIdle,
  output logic              protoInit,
  output logic              fdEnable,
  output logic              brsEnable,
  output logic              txPause,
  output logic              edgeFilter,
  output logic              excDisable,
  output logic              testMode,
  output logic              monitorMode,
  output logic              restrictedMode,
  output logic              noRetransmit,
  output logic              clockStopAck
);
  wrStrobe_t        strobe;
  logic             initReq;
  logic             initRead;
  logic             initBusy;
  logic             cfgEn;
  logic             stopReq;
  logic [REG_W-1:0] regVal;

  can_mode_wr_ctrl #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_ctrl (
    .busWrEn  (busWrEn),
    .busAddr  (busAddr),
    .busWrData(busWrData),
    .initReq  (initReq),
    .initRead (initRead),
    .initBusy (initBusy),
    .cfgEn    (cfgEn),
    .stopReq  (stopReq),
    .txPending(txPending),
    .busIdle  (busIdle),
    .strobe   (strobe)
  );

  can_mode_regs u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busWrData(busWrData),
    .initRead (initRead),
    .initReq  (initReq),
    .cfgEn    (cfgEn),
    .stopReq  (stopReq),
    .regVal   (regVal)
  );

  can_init_xfer #(.SYNC_STAGES(SYNC_STAGES)) u_xfer (
    .clk      (clk),
    .rstN     (rstN),
    .protoClk (protoClk),
    .protoRstN(protoRstN),
    .initReq  (initReq),
    .protoInit(protoInit),
    .initRead (initRead),
    .initBusy (initBusy)
  );

  assign busRdData      = (busAddr == REG_OFFSET) ? regVal : '0;
  assign fdEnable       = regVal[BIT_FD];
  assign brsEnable      = regVal[BIT_BRS];
  assign txPause        = regVal[BIT_TXPAUSE];
  assign edgeFilter     = regVal[BIT_EDGEFLT];
  assign excDisable     = regVal[BIT_NOEXC];
  assign testMode       = regVal[BIT_TEST];
  assign monitorMode    = regVal[BIT_MON];
  assign restrictedMode = regVal[BIT_RESTR];
  assign noRetransmit   = regVal[BIT_NORETX];
  assign clockStopAck   = regVal[BIT_STOPACK];
endmodule

// File: rtl/can_mode_ctrl_chk.sv
module can_mode_ctrl_chk (
  input logic        clk,
  input logic        rstN,
  input logic [31:0] regVal,
  input logic        txPending,
  input logic        busIdle
);
  assert_cfg_rise_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(regVal[1]) |-> $past(regVal[0]));

  assert_test_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(regVal[7]) |-> $past(regVal[1] && regVal[0]));

  assert_noretx_change_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(regVal[6]) |-> $past(regVal[1] && regVal[0]));

  assert_cfg_needs_init_R8: assert property (@(posedge clk) disable iff (!rstN)
    regVal[1] |-> regVal[0]);

  assert_ack_rise_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(regVal[3]) |-> $past(!txPending && busIdle && regVal[0]));

  assert_ack_needs_req_R10: assert property (@(posedge clk) disable iff (!rstN)
    regVal[3] |-> regVal[4]);
endmodule

bind can_mode_ctrl can_mode_ctrl_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regVal   (regVal),
  .txPending(txPending),
  .busIdle  (busIdle)
);

// File: tb/can_mode_ctrl_bench.sv
module can_mode_ctrl_bench;
  localparam logic [7:0] OFS = 8'h18;

  logic        clk = 1'b0;
  logic        protoClk = 1'b0;
  logic        rstN = 1'b0;
  logic        protoRstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busAddr = OFS;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        txPending = 1'b0;
  logic        busIdle = 1'b1;
  logic protoInit, fdEnable, brsEnable, txPause, edgeFilter, excDisable;
  logic testMode, monitorMode, restrictedMode, noRetransmit, clockStopAck;

  int  checks = 0;
  int  failures = 0;
  bit  finished = 1'b0;

  always #5 clk = ~clk;
  always #7 protoClk = ~protoClk;

  can_mode_ctrl u_can_mode_ctrl (
    .clk(clk), .rstN(rstN), .protoClk(protoClk), .protoRstN(protoRstN),
    .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .txPending(txPending), .busIdle(busIdle), .protoInit(protoInit),
    .fdEnable(fdEnable), .brsEnable(brsEnable), .txPause(txPause), .edgeFilter(edgeFilter),
    .excDisable(excDisable), .testMode(testMode), .monitorMode(monitorMode),
    .restrictedMode(restrictedMode), .noRetransmit(noRetransmit), .clockStopAck(clockStopAck)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1;
    busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic waitInit(input logic want, output int n);
    n = 0;
    while (busRdData[0] !== want && n < 16) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic tReset;
    check("R1 reset word", busRdData, 32'h1);
    check("R1 mode outputs", {21'd0, fdEnable, brsEnable, txPause, edgeFilter, excDisable,
          testMode, monitorMode, restrictedMode, noRetransmit, clockStopAck, protoInit}, 32'h1);
  endtask

  task automatic tPlain;
    wr(32'h0000_7301);
    check("R2 plain fields set", busRdData, 32'h0000_7301);
    check("R2 plain outputs", {27'd0, fdEnable, brsEnable, txPause, edgeFilter, excDisable}, 32'h1f);
  endtask

  task automatic tGuarded;
    wr(32'h0000_00E5);
    check("R4 R5 set blocked while locked", busRdData, 32'h0000_0001);
    wr(32'h0000_0003);
    check("R3 cfg unlock while init", busRdData, 32'h0000_0003);
    wr(32'h0000_00E7);
    check("R4 R5 set while unlocked", busRdData, 32'h0000_00E7);
    check("R4 R5 outputs", {28'd0, testMode, monitorMode, restrictedMode, noRetransmit}, 32'hf);
    wr(32'h0000_0041);
    check("R4 zero accepted R5 keep", busRdData, 32'h0000_0041);
    wr(32'h0000_00E1);
    check("R4 set ignored when locked", busRdData, 32'h0000_0041);
    wr(32'h0000_0001);
    check("R5 clear ignored when locked", busRdData, 32'h0000_0041);
    wr(32'h0000_0003);
    wr(32'h0000_0001);
    check("R5 clear accepted when unlocked", busRdData, 32'h0000_0001);
  endtask

  task automatic tInit;
    int n;
    wr(32'h0000_0003);
    wr(32'h0000_0000);
    check("R8 cfg cleared with init", busRdData, 32'h0000_0001);
    wr(32'h0000_0001);
    waitInit(1'b0, n);
    check("R6 init low reaches readback", {31'd0, busRdData[0]}, 32'h0);
    check("R6 latency in bound", (n >= 1 && n <= 15) ? 32'h1 : 32'h0, 32'h1);
    check("R6 protoInit low", {31'd0, protoInit}, 32'h0);
    repeat (10) @(negedge clk);
    check("R7 in-flight write ignored", busRdData, 32'h0000_0000);
    wr(32'h0000_0002);
    check("R3 cfg ignored while init low", busRdData, 32'h0000_0000);
    wr(32'h0000_4000);
    check("R2 plain write with init low", busRdData, 32'h0000_4000);
    check("R2 txPause output", {31'd0, txPause}, 32'h1);
  endtask

  task automatic tClockStop;
    int n;
    txPending = 1'b1;
    busIdle = 1'b0;
    wr(32'h0000_0010);
    waitInit(1'b1, n);
    check("R9 request forces init", busRdData, 32'h0000_0011);
    repeat (3) @(negedge clk);
    check("R9 no ack while pending", {31'd0, clockStopAck}, 32'h0);
    txPending = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 no ack while bus busy", busRdData, 32'h0000_0011);
    busIdle = 1'b1;
    @(negedge clk);
    check("R9 ack one cycle later", busRdData, 32'h0000_0019);
    check("R9 ack output", {31'd0, clockStopAck}, 32'h1);
    wr(32'h0000_0001);
    check("R10 clear request drops ack", busRdData, 32'h0000_0001);
    wr(32'h0000_0009);
    check("R10 ack write ignored", busRdData, 32'h0000_0001);
  endtask

  task automatic tUnimpl;
    wr(32'hFFFF_8C01);
    check("R11 unimplemented bits", busRdData, 32'h0000_0001);
    @(negedge clk);
    busAddr = 8'h1C;
    wr(32'h0000_7301);
    check("R11 other address reads 0", busRdData, 32'h0);
    busAddr = OFS;
    #1;
    check("R11 other address write ignored", busRdData, 32'h0000_0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    protoRstN = 1'b1;
    repeat (2) @(negedge clk);
    tReset();
    tPlain();
    tGuarded();
    tInit();
    tClockStop();
    tUnimpl();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule